// File: doc/BRIEF.md
# Quarter-rate wavefront issue sequencer

This block decides, cycle by cycle, which resident wavefront feeds a 16-lane SIMD engine. A wavefront has 64 work items, and every work item in it runs the same instruction at the same time. One instruction therefore goes to the lanes as four back-to-back quarters of 16 items each. The sequencer holds a few wavefront slots. Each slot has a program counter, an instruction count, an active item count and one dependency bit per instruction.

A producer's result becomes usable only 8 cycles after its first quarter issued. To hide that gap, the sequencer interleaves wavefronts in round-robin order. A wavefront whose next instruction is still waiting on its producer is passed over. When no slot can issue, the engine gets an empty cycle. A wavefront retires after the final quarter of its last instruction and reports a single-cycle completion pulse. A short final wavefront switches off the lanes beyond its item count.

Software or an upstream dispatcher loads a slot with one launch strobe. Fetch, decode and the datapath are outside this block.

Top module: `wave_issue_seq`

## Requirements
- R1: During and right after reset, `issue_valid` and `done_valid` are low and `lane_mask` is all zero.
- R2: Every instruction occupies four consecutive cycles with `issue_quarter` 0, 1, 2, 3, and `issue_wf` and `issue_instr` stay fixed across the four cycles.
- R3: For a wavefront launched with 64 items, `lane_mask` is all ones (0xFFFF) in every quarter it issues.
- R4: Lane l is enabled in quarter q exactly when q*16 + l is below the launched item count. For example, 37 items gives masks 0xFFFF, 0xFFFF, 0x001F and 0x0000.
- R5: Slot selection is round-robin, starting from the slot after the one chosen last, among slots that are ready. Three independent wavefronts in slots 0, 1 and 2 issue as 0000 1111 2222, and that pattern repeats once per instruction.
- R6: The first quarter of a dependent instruction issues no earlier than 8 cycles after the first quarter of the instruction before it in the same wavefront. A lone wavefront of fully dependent instructions shows 4 empty cycles between instructions.
- R7: Two wavefronts whose instructions are all dependent interleave 0000 1111 0000 1111 with no empty cycle.
- R8: A cycle in which no slot can issue has `issue_valid` low and `lane_mask` zero.
- R9: `done_valid` pulses for exactly one cycle, together with the fourth quarter of a wavefront's last instruction, and `done_wf` gives its slot. After that the slot issues nothing more.
- R10: `issue_instr` counts 0, 1, … up to the launch length minus one for each wavefront.
- R11: A launch aimed at a slot that still holds an unfinished wavefront is ignored.
- R12: Bit i of `launch_dep` set means instruction i depends on instruction i-1. Bit 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch_valid | input | 1 | Load a wavefront into a slot this cycle |
| launch_slot | input | 2 | Slot to load |
| launch_len | input | 5 | Instruction count, 1 to 16 |
| launch_items | input | 7 | Active work items, 1 to 64 |
| launch_dep | input | 16 | Per-instruction dependency bits |
| issue_valid | output | 1 | A quarter is issued this cycle |
| issue_wf | output | 2 | Slot being issued |
| issue_quarter | output | 2 | Quarter index 0 to 3 |
| issue_instr | output | 4 | Instruction index within the wavefront |
| lane_mask | output | 16 | Per-lane enable for this quarter |
| done_valid | output | 1 | A wavefront retires this cycle |
| done_wf | output | 2 | Slot that retires |

## Verification
The bench uses the default parameters: four slots, 16 lanes, 64 items, a latency of 8 and up to 16 instructions. With these values the latency is exactly twice the length of one instruction. As a result, one dependent wavefront leaves a 4-cycle gap, and two such wavefronts close that gap exactly, so both edges of the latency rule can be seen. Four slots also allow a partial wavefront in the highest slot and a three-way round-robin across the lower slots.

// File: rtl/wave_issue_seq.sv
module wave_issue_seq #(
  parameter int NUM_WF    = 4,
  parameter int LANES     = 16,
  parameter int WF_ITEMS  = 64,
  parameter int RAW_LAT   = 8,
  parameter int MAX_INSTR = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  launch_valid,
  input  logic [$clog2(NUM_WF)-1:0]             launch_slot,
  input  logic [$clog2(MAX_INSTR+1)-1:0]        launch_len,
  input  logic [$clog2(WF_ITEMS+1)-1:0]         launch_items,
  input  logic [MAX_INSTR-1:0]                  launch_dep,
  output logic                                  issue_valid,
  output logic [$clog2(NUM_WF)-1:0]             issue_wf,
  output logic [$clog2(WF_ITEMS/LANES)-1:0]     issue_quarter,
  output logic [$clog2(MAX_INSTR)-1:0]          issue_instr,
  output logic [LANES-1:0]                      lane_mask,
  output logic                                  done_valid,
  output logic [$clog2(NUM_WF)-1:0]             done_wf
);
  localparam int QUARTERS = WF_ITEMS / LANES;
  localparam int SW = $clog2(NUM_WF);
  localparam int QW = $clog2(QUARTERS);
  localparam int PW = $clog2(MAX_INSTR);
  localparam int LW = $clog2(MAX_INSTR + 1);
  localparam int NW = $clog2(WF_ITEMS + 1);
  localparam int TW = $clog2(RAW_LAT + 1);
  localparam logic [QW-1:0] LASTQ = QW'(QUARTERS - 1);

  logic [NUM_WF-1:0]    act, ready;
  logic [PW-1:0]        pc    [NUM_WF];
  logic [LW-1:0]        len   [NUM_WF];
  logic [NW-1:0]        items [NUM_WF];
  logic [MAX_INSTR-1:0] dep   [NUM_WF];
  logic [TW-1:0]        tmr   [NUM_WF];

  logic          busy, clast, found, advance, take;
  logic [SW-1:0] cur, rr, sel;
  logic [QW-1:0] qtr;
  logic [PW-1:0] ipc;
  logic [NW-1:0] citems;

  for (genvar i = 0; i < NUM_WF; i++) begin : g_ready
    assign ready[i] = act[i] && ((tmr[i] == '0) || !dep[i][pc[i]]);
  end

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int k = 0; k < NUM_WF; k++) begin
      if (!found && ready[(int'(rr) + k) % NUM_WF]) begin
        found = 1'b1;
        sel   = SW'((int'(rr) + k) % NUM_WF);
      end
    end
  end

  assign advance = !busy || (qtr == LASTQ);
  assign take    = advance && found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= '0;
      for (int i = 0; i < NUM_WF; i++) begin
        pc[i] <= '0; len[i] <= '0; items[i] <= '0; dep[i] <= '0; tmr[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_WF; i++) begin
        if (take && sel == SW'(i)) begin
          tmr[i] <= TW'(RAW_LAT - 1);
          pc[i]  <= pc[i] + 1'b1;
          if ((LW'(pc[i]) + LW'(1)) == len[i]) act[i] <= 1'b0;
        end else if (tmr[i] != '0) begin
          tmr[i] <= tmr[i] - 1'b1;
        end
        if (launch_valid && launch_slot == SW'(i) && !act[i]) begin
          act[i]   <= 1'b1;
          pc[i]    <= '0;
          len[i]   <= launch_len;
          items[i] <= launch_items;
          dep[i]   <= launch_dep;
          tmr[i]   <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cur <= '0; qtr <= '0; ipc <= '0;
      citems <= '0; clast <= 1'b0; rr <= '0;
    end else if (advance) begin
      busy <= found;
      if (found) begin
        cur    <= sel;
        qtr    <= '0;
        ipc    <= pc[sel];
        citems <= items[sel];
        clast  <= (LW'(pc[sel]) + LW'(1)) == len[sel];
        rr     <= (sel == SW'(NUM_WF - 1)) ? '0 : sel + 1'b1;
      end
    end else begin
      qtr <= qtr + 1'b1;
    end
  end

  assign issue_valid   = busy;
  assign issue_wf      = cur;
  assign issue_quarter = qtr;
  assign issue_instr   = ipc;
  assign done_valid    = busy && (qtr == LASTQ) && clast;
  assign done_wf       = cur;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_mask[l] = busy && ((int'(qtr) * LANES + l) < int'(citems));
  end

  assert_quarter_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && issue_quarter != LASTQ |=> issue_valid &&
      issue_quarter == $past(issue_quarter) + QW'(1) &&
      $stable(issue_wf) && $stable(issue_instr));

  assert_start_at_q0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(issue_valid) |-> issue_quarter == '0);

  assert_done_on_last_q_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> issue_valid && issue_quarter == LASTQ);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  assert_idle_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> lane_mask == '0 && !done_valid);
endmodule

// File: tb/wave_issue_seq_tb.sv
`timescale 1ns/1ps
module wave_issue_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        launch_valid = 1'b0;
  logic [1:0]  launch_slot = '0;
  logic [4:0]  launch_len = '0;
  logic [6:0]  launch_items = '0;
  logic [15:0] launch_dep = '0;
  logic        issue_valid, done_valid;
  logic [1:0]  issue_wf, issue_quarter, done_wf;
  logic [3:0]  issue_instr;
  logic [15:0] lane_mask;

  wave_issue_seq dut_i (
    .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid), .launch_slot(launch_slot),
    .launch_len(launch_len), .launch_items(launch_items), .launch_dep(launch_dep),
    .issue_valid(issue_valid), .issue_wf(issue_wf), .issue_quarter(issue_quarter),
    .issue_instr(issue_instr), .lane_mask(lane_mask), .done_valid(done_valid),
    .done_wf(done_wf));

  always #2.5 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  bit finished = 0;
  int tr_v[1024], tr_wf[1024], tr_q[1024], tr_i[1024], tr_m[1024], tr_d[1024], tr_dw[1024];

  always @(negedge clk) begin
    if (cyc < 1024) begin
      tr_v[cyc] = int'(issue_valid); tr_wf[cyc] = int'(issue_wf);
      tr_q[cyc] = int'(issue_quarter); tr_i[cyc] = int'(issue_instr);
      tr_m[cyc] = int'(lane_mask); tr_d[cyc] = int'(done_valid); tr_dw[cyc] = int'(done_wf);
    end
    cyc++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic launch(input int slot, input int len, input int items, input logic [15:0] dep);
    @(posedge clk); #1;
    launch_valid = 1'b1; launch_slot = 2'(slot); launch_len = 5'(len);
    launch_items = 7'(items); launch_dep = dep;
  endtask

  task automatic idle_wait(input int n);
    @(posedge clk); #1;
    launch_valid = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  function automatic int first_valid(input int from);
    for (int i = from; i < 1024 && i < cyc; i++) if (tr_v[i] == 1) return i;
    return -1;
  endfunction

  task automatic t_reset;
    @(negedge clk); #0.1;
    chk("R1", "valid in reset", int'(issue_valid), 0);
    chk("R1", "mask in reset", int'(lane_mask), 0);
    chk("R1", "done in reset", int'(done_valid), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk); #0.1;
    chk("R1", "valid after reset", int'(issue_valid), 0);
    chk("R1", "mask after reset", int'(lane_mask), 0);
  endtask

  task automatic t_three_indep;
    int m, f;
    m = cyc;
    launch(0, 2, 64, 16'h0000); launch(1, 2, 64, 16'h0000); launch(2, 2, 64, 16'h0000);
    idle_wait(40);
    f = first_valid(m);
    chk("R5", "first issue found", int'(f >= 0), 1);
    if (f < 0) return;
    for (int k = 0; k < 24; k++) begin
      chk("R5", "valid", tr_v[f+k], 1);
      chk("R5", "slot order", tr_wf[f+k], (k / 4) % 3);
      chk("R2", "quarter", tr_q[f+k], k % 4);
      chk("R10", "instr index", tr_i[f+k], k / 12);
      chk("R3", "full mask", tr_m[f+k], 16'hFFFF);
      chk("R9", "done pulse", tr_d[f+k], int'(k % 4 == 3 && k >= 12));
      if (k % 4 == 3 && k >= 12) chk("R9", "done slot", tr_dw[f+k], (k / 4) % 3);
    end
    chk("R8", "idle after retire", tr_v[f+24], 0);
    chk("R8", "idle mask", tr_m[f+24], 0);
  endtask

  task automatic t_single_dep;
    int m, f, e;
    m = cyc;
    launch(0, 3, 64, 16'b110);
    idle_wait(40);
    f = first_valid(m);
    chk("R6", "first issue found", int'(f >= 0), 1);
    if (f < 0) return;
    for (int k = 0; k < 20; k++) begin
      e = int'((k % 8) < 4);
      chk("R6", "valid pattern", tr_v[f+k], e);
      if (e == 1) begin
        chk("R10", "instr index", tr_i[f+k], k / 8);
        chk("R2", "quarter", tr_q[f+k], k % 4);
      end else begin
        chk("R8", "bubble mask", tr_m[f+k], 0);
      end
    end
    chk("R9", "done at end", tr_d[f+19], 1);
  endtask

  task automatic t_dep_bit0;
    int m, f, e, ins;
    m = cyc;
    launch(0, 3, 64, 16'b101);
    idle_wait(40);
    f = first_valid(m);
    chk("R12", "first issue found", int'(f >= 0), 1);
    if (f < 0) return;
    for (int k = 0; k < 16; k++) begin
      e = int'(k < 8 || k >= 12);
      ins = (k < 4) ? 0 : ((k < 8) ? 1 : 2);
      chk("R12", "valid pattern", tr_v[f+k], e);
      if (e == 1) chk("R12", "instr index", tr_i[f+k], ins);
    end
  endtask

  task automatic t_two_dep;
    int m, f;
    m = cyc;
    launch(0, 2, 64, 16'b10); launch(1, 2, 64, 16'b10);
    idle_wait(40);
    f = first_valid(m);
    chk("R7", "first issue found", int'(f >= 0), 1);
    if (f < 0) return;
    for (int k = 0; k < 16; k++) begin
      chk("R7", "no bubble", tr_v[f+k], 1);
      chk("R7", "slot order", tr_wf[f+k], (k / 4) % 2);
      chk("R7", "instr index", tr_i[f+k], k / 8);
    end
    chk("R7", "idle after", tr_v[f+16], 0);
  endtask

  task automatic t_partial;
    int m, f;
    int exp37[4] = '{16'hFFFF, 16'hFFFF, 16'h001F, 16'h0000};
    m = cyc;
    launch(3, 1, 37, 16'h0);
    idle_wait(20);
    f = first_valid(m);
    chk("R4", "first issue found", int'(f >= 0), 1);
    if (f < 0) return;
    for (int k = 0; k < 4; k++) begin
      chk("R4", "37-item mask", tr_m[f+k], exp37[k]);
      chk("R4", "slot", tr_wf[f+k], 3);
    end
    chk("R9", "done slot 3", tr_dw[f+3], 3);
    m = cyc;
    launch(2, 1, 1, 16'h0);
    idle_wait(20);
    f = first_valid(m);
    chk("R4", "first issue found", int'(f >= 0), 1);
    if (f < 0) return;
    chk("R4", "1-item q0", tr_m[f], 16'h0001);
    chk("R4", "1-item q1", tr_m[f+1], 0);
  endtask

  task automatic t_occupied;
    int m, f, nd;
    m = cyc;
    launch(0, 3, 64, 16'b110);
    launch(0, 1, 16, 16'h0);
    idle_wait(50);
    f = first_valid(m);
    chk("R11", "first issue found", int'(f >= 0), 1);
    if (f < 0) return;
    for (int k = 0; k < 20; k++)
      if ((k % 8) < 4) chk("R11", "mask kept 64 items", tr_m[f+k], 16'hFFFF);
    chk("R11", "third instr issued", tr_i[f+16], 2);
    nd = 0;
    for (int k = 0; k < 40; k++) nd += tr_d[f+k];
    chk("R11", "single retire", nd, 1);
    chk("R11", "retire position", tr_d[f+19], 1);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_three_indep();
    t_single_dep();
    t_dep_bit0();
    t_two_dep();
    t_partial();
    t_occupied();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule